// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Sequencer

This block turns one host request at a time into a single read or write on an asynchronous external memory such as NOR Flash, SRAM or PSRAM. The access runs as a chain of phases: address setup, an address hold phase that exists only on a shared address/data bus, data setup, and a gap that lets the bus turn around. Each phase has its own programmed length in host clock cycles. The top two bits of the host address pick one of four chip selects, and the low 26 bits go out on the external address pins.

The host presents a request while `req_ready` is high. The timing settings and the request fields are captured on that cycle, so they may change once the access has begun. When the turnaround gap is over, the block returns to idle, raises `done` for one cycle and, after a read, holds the returned data on `rd_data`. In shared-bus mode the low address bits also go out on the data lines and are latched by the memory on the address strobe.

Top module: `extmem_async_seq`

## Requirements
- R1: After reset all chip selects, `oe_n`, `we_n` and `adv_n` are high, `dq_oe` and `done` are low and `req_ready` is high.
- R2: Address setup lasts `cfg_addr_setup` cycles (0 to 15) with `adv_n` low and the selected chip select low; a value of 0 leaves out the phase and `adv_n` never falls.
- R3: When `cfg_mux` is 1, an address hold phase of `cfg_addr_hold` cycles follows address setup, with 0 treated as 1; during setup and hold `dq_oe` is 1 and `dq_o` carries address bits 15:0. When `cfg_mux` is 0 there is no hold phase and `dq_oe` stays 0 during setup.
- R4: Data setup lasts `cfg_data_setup` + 1 cycles (1 to 256).
- R5: On a read (`req_write` = 0) `oe_n` is low and `we_n` high for all of data setup, `dq_oe` is 0, and `rd_data` shows the value of `dq_i` from the last data setup cycle.
- R6: On a write (`req_write` = 1) `we_n` is low and `oe_n` high for all of data setup, with `dq_oe` = 1 and `dq_o` equal to the write data.
- R7: Turnaround lasts `cfg_turn` cycles (0 to 15), with every chip select and strobe high and `dq_oe` = 0.
- R8: `req_addr[27:26]` selects the chip select: value k drives `ce_n[k]` low and leaves the others high, from the start of address setup to the end of data setup. `mem_addr` equals `req_addr[25:0]` throughout.
- R9: `req_ready` is high only when idle; `done` is high for exactly one cycle, the first idle cycle after the access.
- R10: A request presented while an access is in progress is ignored and does not change the pins of the access already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Bank select (27:26) and memory address (25:0) |
| req_wdata | input | 16 | Write data |
| cfg_addr_setup | input | 4 | Address setup cycles |
| cfg_addr_hold | input | 4 | Address hold cycles, shared-bus mode only |
| cfg_data_setup | input | 8 | Data setup cycles minus one |
| cfg_turn | input | 4 | Turnaround cycles |
| cfg_mux | input | 1 | 1 = address shares the data lines |
| req_ready | output | 1 | Idle; a request is accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| mem_addr | output | 26 | External address bus |
| dq_o | output | 16 | Data bus output value |
| dq_oe | output | 1 | Data bus drive enable |
| dq_i | input | 16 | Data bus input value |
| ce_n | output | 4 | Active-low chip selects |
| oe_n | output | 1 | Active-low output enable |
| we_n | output | 1 | Active-low write enable |
| adv_n | output | 1 | Active-low address latch strobe |

## Verification
The bench counts the cycles spent in each phase from the pin pattern alone and compares them against the settings. It covers a zero address setup, which a faulty design would stretch to one strobe cycle, a zero hold setting in shared-bus mode, which would give no hold phase or a hold that never ends, and a zero turnaround, which would delay `done` or make it last longer than one cycle. The 256-cycle data setup exposes a counter that is one bit too narrow or off by one. A request sent in the middle of an access catches a sequencer that restarts, or that changes its address or direction, before the turnaround has ended.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASET = 3'd1,
    PH_AHLD = 3'd2,
    PH_DSET = 3'd3,
    PH_TURN = 3'd4
  } phase_e;

endpackage

// File: rtl/extmem_phase_cnt.sv
// Down-counter for phase length: loaded with (length - 1) on phase entry,
// flags the final cycle of the phase when it reaches zero.
module extmem_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/extmem_bank_dec.sv
// One active-low select per bank, driven while an access owns the bus.
module extmem_bank_dec #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2
) (
  input  logic              active,
  input  logic [BANK_W-1:0] bank,
  output logic [BANKS-1:0]  ce_n
);

  for (genvar g = 0; g < BANKS; g++) begin : g_sel
    assign ce_n[g] = ~(active && (bank == BANK_W'(g)));
  end

endmodule

// File: rtl/extmem_pin_drv.sv
// Strobe and data-bus decode from the current phase.
module extmem_pin_drv
  import extmem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  phase_e            phase,
  input  logic              is_wr,
  input  logic              mux,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic              active,
  output logic              adv_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_o
);

  logic addr_ph;
  logic data_ph;

  always_comb begin
    addr_ph = (phase == PH_ASET) || (phase == PH_AHLD);
    data_ph = (phase == PH_DSET);
    active  = addr_ph || data_ph;
    adv_n   = ~(phase == PH_ASET);
    oe_n    = ~(data_ph && !is_wr);
    we_n    = ~(data_ph && is_wr);
    dq_oe   = (addr_ph && mux) || (data_ph && is_wr);
    dq_o    = '0;
    if (addr_ph && mux) begin
      dq_o = addr_lo;
    end else if (data_ph && is_wr) begin
      dq_o = wdata;
    end
  end

endmodule

// File: rtl/extmem_async_seq.sv
module extmem_async_seq
  import extmem_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int BANKS  = 4,
  parameter int SET_W  = 4,
  parameter int DS_W   = 8,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int HOST_AW = ADDR_W + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [SET_W-1:0]   cfg_addr_setup,
  input  logic [SET_W-1:0]   cfg_addr_hold,
  input  logic [DS_W-1:0]    cfg_data_setup,
  input  logic [SET_W-1:0]   cfg_turn,
  input  logic               cfg_mux,
  output logic               req_ready,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  dq_o,
  output logic               dq_oe,
  input  logic [DATA_W-1:0]  dq_i,
  output logic [BANKS-1:0]   ce_n,
  output logic               oe_n,
  output logic               we_n,
  output logic               adv_n
);

  localparam int CNT_W = (DS_W > SET_W) ? DS_W : SET_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta;
  logic rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  phase_e              phase_q, phase_d;
  logic                wr_q, mux_q;
  logic [HOST_AW-1:0]  addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [SET_W-1:0]    hold_q, turn_q;
  logic [DS_W-1:0]     dset_q;
  logic [DATA_W-1:0]   rd_q;
  logic                done_q, done_d;

  logic                accept;
  logic                cap_rd;
  logic                cnt_load;
  logic [CNT_W-1:0]    cnt_val;
  logic                cnt_last;
  logic                pins_active;

  function automatic logic [CNT_W-1:0] hold_len_m1(input logic [SET_W-1:0] h);
    return (h == '0) ? '0 : (CNT_W'(h) - CNT_W'(1));
  endfunction

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    done_d   = 1'b0;
    accept   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          cnt_load = 1'b1;
          if (cfg_addr_setup != '0) begin
            phase_d = PH_ASET;
            cnt_val = CNT_W'(cfg_addr_setup) - CNT_W'(1);
          end else if (cfg_mux) begin
            phase_d = PH_AHLD;
            cnt_val = hold_len_m1(cfg_addr_hold);
          end else begin
            phase_d = PH_DSET;
            cnt_val = CNT_W'(cfg_data_setup);
          end
        end
      end
      PH_ASET: begin
        if (cnt_last) begin
          cnt_load = 1'b1;
          if (mux_q) begin
            phase_d = PH_AHLD;
            cnt_val = hold_len_m1(hold_q);
          end else begin
            phase_d = PH_DSET;
            cnt_val = CNT_W'(dset_q);
          end
        end
      end
      PH_AHLD: begin
        if (cnt_last) begin
          cnt_load = 1'b1;
          phase_d  = PH_DSET;
          cnt_val  = CNT_W'(dset_q);
        end
      end
      PH_DSET: begin
        if (cnt_last) begin
          if (turn_q != '0) begin
            cnt_load = 1'b1;
            phase_d  = PH_TURN;
            cnt_val  = CNT_W'(turn_q) - CNT_W'(1);
          end else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      PH_TURN: begin
        if (cnt_last) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    cap_rd = (phase_q == PH_DSET) && cnt_last && !wr_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  // request and timing capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wr_q    <= 1'b0;
      mux_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
      dset_q  <= '0;
      turn_q  <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      mux_q   <= cfg_mux;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      hold_q  <= cfg_addr_hold;
      dset_q  <= cfg_data_setup;
      turn_q  <= cfg_turn;
    end
  end

  // read data capture, enabled on the last data setup cycle
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rd_q <= '0;
    end else if (cap_rd) begin
      rd_q <= dq_i;
    end
  end

  extmem_phase_cnt #(
    .W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  extmem_pin_drv #(
    .DATA_W (DATA_W)
  ) u_pins (
    .phase   (phase_q),
    .is_wr   (wr_q),
    .mux     (mux_q),
    .addr_lo (addr_q[DATA_W-1:0]),
    .wdata   (wdata_q),
    .active  (pins_active),
    .adv_n   (adv_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .dq_oe   (dq_oe),
    .dq_o    (dq_o)
  );

  extmem_bank_dec #(
    .BANKS  (BANKS),
    .BANK_W (BANK_W)
  ) u_bank (
    .active (pins_active),
    .bank   (addr_q[HOST_AW-1:ADDR_W]),
    .ce_n   (ce_n)
  );

  assign req_ready = (phase_q == PH_IDLE);
  assign done      = done_q;
  assign rd_data   = rd_q;
  assign mem_addr  = addr_q[ADDR_W-1:0];

endmodule

// File: rtl/extmem_async_seq_chk.sv
module extmem_async_seq_chk #(
  parameter int ADDR_W = 26,
  parameter int BANKS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic [BANKS-1:0]  ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              adv_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  p_one_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ce_n) && $past(!(&ce_n))) |-> $stable(mem_addr));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_write_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  p_latch_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> !(&ce_n));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!dq_oe && (&ce_n) && oe_n && we_n && adv_n));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

endmodule

bind extmem_async_seq extmem_async_seq_chk #(
  .ADDR_W (ADDR_W),
  .BANKS  (BANKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .adv_n     (adv_n),
  .dq_oe     (dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/extmem_async_seq_tb.sv
module extmem_async_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [27:0] req_addr;
  logic [15:0] req_wdata;
  logic [3:0]  cfg_addr_setup, cfg_addr_hold, cfg_turn;
  logic [7:0]  cfg_data_setup;
  logic        cfg_mux;
  logic        req_ready, done;
  logic [15:0] rd_data, dq_o, dq_i;
  logic [25:0] mem_addr;
  logic        dq_oe;
  logic [3:0]  ce_n;
  logic        oe_n, we_n, adv_n;

  int n_vec = 0;
  int n_bad = 0;
  bit wd_hit = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [25:0] a);
    return a[15:0] ^ 16'hC35A ^ {6'b0, a[25:16]};
  endfunction

  assign dq_i = oe_n ? 16'h0000 : mem_word(mem_addr);

  extmem_async_seq u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .cfg_addr_setup (cfg_addr_setup),
    .cfg_addr_hold  (cfg_addr_hold),
    .cfg_data_setup (cfg_data_setup),
    .cfg_turn       (cfg_turn),
    .cfg_mux        (cfg_mux),
    .req_ready      (req_ready),
    .done           (done),
    .rd_data        (rd_data),
    .mem_addr       (mem_addr),
    .dq_o           (dq_o),
    .dq_oe          (dq_oe),
    .dq_i           (dq_i),
    .ce_n           (ce_n),
    .oe_n           (oe_n),
    .we_n           (we_n),
    .adv_n          (adv_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One access; the phase lengths are measured from the pins only.
  task automatic run(input bit wr, input bit mux, input logic [27:0] a,
                     input logic [15:0] wd, input int as, input int ah,
                     input int ds, input int tn, input bit glitch);
    int n_as = 0, n_ah = 0, n_ds = 0, n_tn = 0;
    int bad_ce = 0, bad_mx = 0, bad_rd = 0, bad_wr = 0, bad_tn = 0, bad_rdy = 0;
    bit got_done = 1'b0;
    int exp_ah;
    logic [3:0] exp_ce;
    exp_ah = mux ? ((ah == 0) ? 1 : ah) : 0;
    exp_ce = ~(4'b0001 << a[27:26]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    cfg_addr_setup = 4'(as); cfg_addr_hold = 4'(ah);
    cfg_data_setup = 8'(ds); cfg_turn = 4'(tn); cfg_mux = mux;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (c == 0) begin
        // change settings right away: the running access must not see them
        cfg_addr_setup = 4'd9; cfg_data_setup = 8'd40; cfg_mux = ~mux;
      end
      if (done) begin
        got_done = 1'b1;
        req_valid = 1'b0;
        break;
      end
      if (req_ready) bad_rdy++;
      if (!(&ce_n)) begin
        if (ce_n != exp_ce || mem_addr != a[25:0]) bad_ce++;
      end
      if (!adv_n) begin
        n_as++;
        if (mux ? !(dq_oe && dq_o == a[15:0]) : dq_oe) bad_mx++;
      end else if (!(&ce_n) && oe_n && we_n) begin
        n_ah++;
        if (!(dq_oe && dq_o == a[15:0])) bad_mx++;
      end else if (!oe_n) begin
        n_ds++;
        if (wr || !we_n || dq_oe) bad_rd++;
      end else if (!we_n) begin
        n_ds++;
        if (!wr || !oe_n || !dq_oe || dq_o != wd) bad_wr++;
      end else begin
        n_tn++;
        if (dq_oe || !adv_n || !oe_n || !we_n || !(&ce_n)) bad_tn++;
      end
      if (glitch && c == 0) begin
        req_valid = 1'b1; req_write = ~wr; req_addr = a ^ 28'h5555AA;
      end else begin
        req_valid = 1'b0;
      end
    end
    chk(got_done, "R9", "done seen", got_done, 1);
    chk(n_as == as, "R2", "address setup cycles", n_as, as);
    chk(n_ah == exp_ah, "R3", "address hold cycles", n_ah, exp_ah);
    chk(bad_mx == 0, "R3", "address on data lines", bad_mx, 0);
    chk(n_ds == ds + 1, "R4", "data setup cycles", n_ds, ds + 1);
    chk(n_tn == tn, "R7", "turnaround cycles", n_tn, tn);
    chk(bad_tn == 0, "R7", "bus released in turnaround", bad_tn, 0);
    chk(bad_ce == 0, "R8", "chip select and address", bad_ce, 0);
    chk(bad_rdy == 0, "R9", "ready low while busy", bad_rdy, 0);
    chk(req_ready == 1'b1, "R9", "ready at done", req_ready, 1);
    if (wr) chk(bad_wr == 0, "R6", "write strobes and data", bad_wr, 0);
    else begin
      chk(bad_rd == 0, "R5", "read strobes", bad_rd, 0);
      chk(rd_data == mem_word(a[25:0]), "R5", "read data", rd_data, mem_word(a[25:0]));
    end
    if (glitch) begin
      chk(bad_ce == 0 && bad_rd == 0 && bad_wr == 0, "R10", "busy request ignored",
          bad_ce + bad_rd + bad_wr, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done lasts one cycle", done, 0);
    if (glitch) chk(req_ready == 1'b1, "R10", "no second access started", req_ready, 1);
  endtask

  task automatic t_reset();
    chk(&ce_n, "R1", "chip selects high", ce_n, 15);
    chk(oe_n && we_n && adv_n, "R1", "strobes high", {oe_n, we_n, adv_n}, 7);
    chk(!dq_oe && !done, "R1", "bus and done low", {dq_oe, done}, 0);
    chk(req_ready, "R1", "ready", req_ready, 1);
  endtask

  task automatic t_read_basic();     run(0, 0, 28'h5012345, 16'h0, 2, 0, 2, 1, 0);  endtask
  task automatic t_write_basic();    run(1, 0, 28'hA3F0F0C, 16'hBEEF, 3, 0, 4, 2, 0); endtask
  task automatic t_zero_setup();     run(0, 0, 28'h0000ABC, 16'h0, 0, 5, 0, 0, 0);  endtask
  task automatic t_mux_read();       run(0, 1, 28'hF1234AB, 16'h0, 2, 3, 1, 2, 0);  endtask
  task automatic t_mux_min_hold();   run(1, 1, 28'h7777777, 16'h1357, 1, 0, 0, 0, 0); endtask
  task automatic t_mux_no_setup();   run(0, 1, 28'h2468ACE, 16'h0, 0, 2, 3, 1, 0);  endtask
  task automatic t_long_data();      run(1, 0, 28'hC000001, 16'hFFFF, 15, 0, 255, 15, 0); endtask
  task automatic t_busy_ignored();   run(0, 0, 28'h4ACE123, 16'h0, 1, 0, 5, 2, 1);  endtask
  task automatic t_back_to_back();
    run(1, 0, 28'h8001000, 16'h00FF, 1, 0, 1, 0, 0);
    run(0, 0, 28'h0002000, 16'h0, 1, 0, 1, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_addr_setup = '0; cfg_addr_hold = '0; cfg_data_setup = '0; cfg_turn = '0; cfg_mux = 1'b0;
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_read_basic();
        t_write_basic();
        t_zero_setup();
        t_mux_read();
        t_mux_min_hold();
        t_mux_no_setup();
        t_long_data();
        t_busy_ignored();
        t_back_to_back();
      end
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) chk(1'b0, "R9", "watchdog expired", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule